// File: doc/BRIEF.md
# MLT-3 Transmit Serializer

This block is the digital transmit path of a 100 Mb/s copper line interface. It runs from a single fast bit clock and derives a one-in-five clock enable from it, which paces a 5-bit code-group interface. On each enable edge the block captures the presented code group into a holding register. At the same edge it moves the previous code group into a parallel-in serial-out shifter. The shifter emits one bit per fast cycle, least significant bit first.

The serial NRZ bits are turned into an NRZI level, which toggles on every one. Each NRZI toggle advances a four-phase MLT-3 sequencer. The sequencer output is a signed two-bit line level that feeds the analog driver. A speed-select input chooses whether this fast path drives the line. When speed-select is low, the output is parked at the zero level and the sequencer keeps running inside.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `mlt_level` = 2'b00 and `nib_ce` = 0.
- R2: `nib_ce` is high for one cycle in every five. After reset it first goes high after the fourth rising edge that samples `rst_n` high.
- R3: `tx_word` is sampled only at a rising edge where `nib_ce` is high. Values driven in the other four cycles have no effect on the line output.
- R4: A word captured at edge A is sent bit 0 first. Bit i causes its line-level change, if any, at edge A+7+i, so five bits are sent per enable period.
- R5: A serial one changes the line level by exactly one MLT-3 step. A serial zero leaves the level unchanged.
- R6: Line codes are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. Code 2'b10 never appears. The level never moves directly between +1 and -1.
- R7: While `speed_hi` is low, `mlt_level` is 2'b00. The sequencer keeps advancing, and when `speed_hi` returns high the output shows its current phase.
- R8: After reset, the sequence of steps is +1, 0, -1, 0, +1, and so on. The first serial one gives 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial bit clock (125 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_hi | input | 1 | High: the 100 Mb/s path drives the line; low: output parked at zero |
| tx_word | input | 5 | Code group, sampled when `nib_ce` is high |
| nib_ce | output | 1 | One-in-five clock enable (25 MHz word rate) |
| mlt_level | output | 2 | Signed MLT-3 line level |

## Verification
The following properties are checked on every cycle:
- the five-cycle spacing and single-cycle width of `nib_ce`;
- the absence of code 2'b10;
- the ban on jumping straight between +1 and -1;
- the parked zero while `speed_hi` is low.

Other behaviour shows only in the bench's scenarios. The bench decodes the line back into bits and compares the recovered words after the seven-cycle latency, with garbage driven between enable edges. It also checks the exact step order from reset and the hidden advance of the sequencer while the output is parked.

// File: rtl/mlt3_tx_pkg.sv
// Package: MLT-3 phase type and the helper functions for the phase sequence
// and the line codes. Assumes two-bit signed line codes.
package mlt3_tx_pkg;

    typedef enum logic [1:0] {
        PH_ZERO_UP = 2'd0,
        PH_POS     = 2'd1,
        PH_ZERO_DN = 2'd2,
        PH_NEG     = 2'd3
    } mlt_phase_e;

    localparam logic [1:0] CODE_ZERO = 2'b00;
    localparam logic [1:0] CODE_POS  = 2'b01;
    localparam logic [1:0] CODE_NEG  = 2'b11;

    // Next phase in the cycle 0 -> +1 -> 0 -> -1 -> 0.
    function automatic mlt_phase_e next_phase(input mlt_phase_e ph);
        case (ph)
            PH_ZERO_UP: return PH_POS;
            PH_POS:     return PH_ZERO_DN;
            PH_ZERO_DN: return PH_NEG;
            default:    return PH_ZERO_UP;
        endcase
    endfunction

    // Line code that belongs to a phase.
    function automatic logic [1:0] phase_code(input mlt_phase_e ph);
        case (ph)
            PH_POS:  return CODE_POS;
            PH_NEG:  return CODE_NEG;
            default: return CODE_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/mlt3_tx_phase.sv
// Modulo-RATIO phase counter. It produces the word-rate strobe from the fast
// clock. Assumes RATIO >= 2. The strobe is high in the last count of each period.
module mlt3_tx_phase #(
    parameter int RATIO = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_stb
);
    localparam int            CW   = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    // Count 0..RATIO-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign load_stb = (cnt == LAST);
endmodule

// File: rtl/mlt3_tx_shifter.sv
// Double-buffered serializer: a holding register, then a PISO that shifts LSB
// first. The last stage is an NRZI toggle flop.
// Assumes load_stb pulses once every W cycles.
module mlt3_tx_shifter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] word_in,
    output logic         nrzi_bit
);
    logic [W-1:0] hold_q;
    logic [W-1:0] piso_q;
    logic         nrzi_q;

    // Capture the incoming word on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (load_stb) hold_q <= word_in;
    end

    // Reload from the holding register on the strobe, otherwise shift right.
    always_ff @(posedge clk) begin
        if (!rst_n)        piso_q <= '0;
        else if (load_stb) piso_q <= hold_q;
        else               piso_q <= {1'b0, piso_q[W-1:1]};
    end

    // NRZ to NRZI: toggle on a one, hold on a zero.
    always_ff @(posedge clk) begin
        if (!rst_n) nrzi_q <= 1'b0;
        else        nrzi_q <= nrzi_q ^ piso_q[0];
    end

    assign nrzi_bit = nrzi_q;
endmodule

// File: rtl/mlt3_tx_encoder.sv
// MLT-3 sequencer. It advances one phase on every NRZI transition.
// Assumes a fresh NRZI bit every clock.
module mlt3_tx_encoder
    import mlt3_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nrzi_bit,
    output logic [1:0] level
);
    logic       nrzi_prev;
    mlt_phase_e phase_q;
    logic       step;

    assign step = nrzi_bit ^ nrzi_prev;

    // Remember the previous NRZI level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nrzi_prev <= 1'b0;
        else        nrzi_prev <= nrzi_bit;
    end

    // Step the phase on a transition.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= PH_ZERO_UP;
        else if (step) phase_q <= next_phase(phase_q);
    end

    assign level = phase_code(phase_q);
endmodule

// File: rtl/mlt3_tx_serializer.sv
// Top level: phase counter, double-buffered NRZI serializer and MLT-3
// sequencer. The line is parked at zero when the high-speed path is
// deselected. Assumes a single fast clock and a synchronous reset.
module mlt3_tx_serializer
    import mlt3_tx_pkg::*;
#(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_hi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              nib_ce,
    output logic [1:0]        mlt_level
);
    logic       load_stb;
    logic       nrzi_bit;
    logic [1:0] enc_level;

    mlt3_tx_phase #(.RATIO(WORD_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb)
    );

    mlt3_tx_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .word_in  (tx_word),
        .nrzi_bit (nrzi_bit)
    );

    mlt3_tx_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .nrzi_bit (nrzi_bit),
        .level    (enc_level)
    );

    assign nib_ce    = load_stb;
    assign mlt_level = speed_hi ? enc_level : CODE_ZERO;
endmodule

// File: rtl/mlt3_tx_checker.sv
// Cycle-level checks on the serializer ports. Bound into the top module.
module mlt3_tx_checker #(
    parameter int RATIO = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       speed_hi,
    input logic       nib_ce,
    input logic [1:0] mlt_level
);
    localparam int GW = $clog2(RATIO + 1);

    logic [GW-1:0] gap;

    // Independent count of the cycles since the last enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      gap <= '0;
        else if (nib_ce) gap <= '0;
        else             gap <= gap + 1'b1;
    end

    p_ce_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_ce |-> (gap == GW'(RATIO - 1)));

    p_ce_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nib_ce |=> !nib_ce);

    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mlt_level != 2'b10);

    p_no_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_hi && $past(speed_hi) && $past(mlt_level) != 2'b00)
        |-> (mlt_level == 2'b00 || mlt_level == $past(mlt_level)));

    p_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_hi |-> (mlt_level == 2'b00));
endmodule

bind mlt3_tx_serializer mlt3_tx_checker #(.RATIO(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_hi  (speed_hi),
    .nib_ce    (nib_ce),
    .mlt_level (mlt_level)
);

// File: tb/tb_mlt3_tx_serializer.sv
module tb_mlt3_tx_serializer;
    localparam int CLK_PERIOD = 8;
    localparam int NVEC       = 16;
    localparam logic [4:0] VEC [NVEC] = '{
        5'h00, 5'h1F, 5'h15, 5'h0A, 5'h01, 5'h10, 5'h03, 5'h18,
        5'h07, 5'h1C, 5'h11, 5'h0E, 5'h13, 5'h19, 5'h06, 5'h1B
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_hi = 1'b1;
    logic [4:0] tx_word = '0;
    wire        nib_ce;
    wire  [1:0] mlt_level;

    int  pc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  rec [0:4095];
    logic [1:0] prev_lvl = 2'b00;
    int  a_cap [NVEC];

    mlt3_tx_serializer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_hi  (speed_hi),
        .tx_word   (tx_word),
        .nib_ce    (nib_ce),
        .mlt_level (mlt_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge counter: at a negedge, pc is the index of the last rising edge.
    always @(posedge clk) pc <= pc + 1;

    // Decoder: any level change is a recovered one.
    always @(negedge clk) begin
        if (pc < 4096) rec[pc] = (mlt_level != prev_lvl);
        prev_lvl = mlt_level;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, pc);
        end
    endtask

    task automatic wait_pc(input int t);
        while (pc < t) @(negedge clk);
    endtask

    task automatic wait_ce();
        do @(negedge clk); while (!nib_ce);
    endtask

    initial begin
        int a0;
        logic [1:0] seq [5];
        seq = '{2'b01, 2'b00, 2'b11, 2'b00, 2'b01};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 level in reset", 32'(mlt_level), 32'h0);
        chk("R1 nib_ce in reset", 32'(nib_ce), 32'h0);
        rst_n = 1'b1;

        // R2: first enable after the fourth edge with rst_n high
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R2 first enable", 32'(nib_ce), (i == 4) ? 32'h1 : 32'h0);
        end

        // Stream the table with garbage between enables (R3, R4, R5)
        for (int k = 0; k < NVEC; k++) begin
            tx_word  = VEC[k];
            a_cap[k] = pc + 1;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                tx_word = 5'($urandom);
            end
            @(negedge clk);
            chk("R2 enable period", 32'(nib_ce), 32'h1);
        end
        tx_word = '0;
        wait_pc(a_cap[NVEC-1] + 12);
        for (int k = 0; k < NVEC; k++)
            for (int i = 0; i < 5; i++)
                chk("R3 R4 R5 recovered bit", 32'(rec[a_cap[k] + 7 + i]), 32'(VEC[k][i]));

        // R8 / R6: step order from reset with an all-ones word
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_ce();
        tx_word = 5'b11111;
        a0 = pc + 1;
        wait_ce();
        tx_word = 5'b00011;
        @(negedge clk);
        tx_word = '0;
        for (int i = 0; i < 5; i++) begin
            wait_pc(a0 + 7 + i);
            chk("R8 R6 step order", 32'(mlt_level), 32'(seq[i]));
        end

        // R7: parked output, sequencer keeps running
        speed_hi = 1'b0;
        wait_pc(a0 + 12);
        chk("R7 parked", 32'(mlt_level), 32'h0);
        wait_pc(a0 + 13);
        chk("R7 parked", 32'(mlt_level), 32'h0);
        wait_pc(a0 + 15);
        speed_hi = 1'b1;
        #1;
        chk("R7 hidden advance", 32'(mlt_level), 32'h3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule